// File: doc/BRIEF.md
# Fractional Q15/Q31 Multiplier

This block is a registered signed fractional multiplier for a DSP datapath. It works on a 32-bit operand pair in one of two ways. Most modes treat each operand as two packed 16-bit lanes. The Q31 mode treats each operand as one signed 32-bit word.

Fractional products are doubled so that the binary point realigns. Two variants narrow each lane to a 16-bit Q15 result, one with rounding and one with plain truncation. Two integer forms share the lane hardware: a signed 16x16 multiply that keeps the low half, and an unsigned byte-by-halfword multiply that saturates.

The one fractional case that cannot be represented is minus one times minus one. That case is forced to the largest positive value and raises an overflow. Each overflow sets a bit in a sticky 32-bit status word. The bit is either a general multiply flag or a flag chosen by a 2-bit accumulator index.

The result appears one cycle after the operation is presented. Mode codes 6 and 7 give a zero result and raise no flag.

Top module: `fixq_mul`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` holds that operation's value. When `in_valid` is low, `out_valid` goes low after the edge and `result` keeps its previous value.
- R2: Mode 0 (packed Q15). For each lane i (bits 16i+15:16i of both operands), the signed product doubled is placed in `result` bits 32i+31:32i.
- R3: In mode 0, a lane whose two operands are both 0x8000 yields 0x7FFFFFFF in its slot and raises overflow.
- R4: Mode 3 (Q31). The signed 32x32 product doubled fills all 64 bits of `result`. When both operands are 0x80000000, the result is 0x7FFFFFFFFFFFFFFF and overflow is raised.
- R5: Mode 1 (rounded Q15). Each lane adds 0x8000 to its doubled product and places bits 31:16 of the sum in `result` bits 16i+15:16i. A lane with both operands 0x8000 gives 0x7FFF and raises overflow. `result` bits 63:32 are zero.
- R6: Mode 2 (truncated Q15). Each lane places bits 31:16 of its doubled product in bits 16i+15:16i. The case with both operands 0x8000 gives 0x7FFF and raises overflow.
- R7: Mode 4 (integer). Each lane gives the low 16 bits of the signed 16x16 product. Overflow is raised when the product lies outside -32768..32767.
- R8: Mode 5 (unsigned byte by halfword). Lane i multiplies the unsigned byte in operand A bits 16i+7:16i by the unsigned halfword of operand B. A product above 0xFFFF gives 0xFFFF and raises overflow.
- R9: An overflow from an operation sets one status bit. With `acc_tgt` low this is bit 21. With `acc_tgt` high it is bit 16 plus `acc_idx`, so bits 16 to 19. Overflow in both lanes of one operation still sets just that one bit.
- R10: Status bits are sticky: once set, a bit stays set until reset. Reset clears `status`, `result` and `out_valid`. No other status bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 3 | Operation code, 0 to 5 |
| acc_tgt | input | 1 | Route overflow to an accumulator flag |
| acc_idx | input | 2 | Accumulator index for flag routing |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered product |
| status | output | 32 | Sticky overflow flags |

## Verification
Two pairs of events can meet in one operation.

The first pair is overflow in both lanes at once. The bench provokes it in integer mode and in rounded Q15 mode with both lanes at their limits. It judges that each lane's saturated or wrapped value lands in its own slot and that exactly one status bit is set.

The second pair is a fresh overflow arriving while other flags are already set. The bench builds up flags on several accumulator indices and then on the general bit. It checks the whole status word after each step against its own running copy, so a lost or misplaced bit shows up.

// File: rtl/fmul_pkg.sv
// Shared types for the fractional multiplier.
// Assumes: mode codes are fixed by the decode stage feeding this block.
package fmul_pkg;
    typedef enum logic [2:0] {
        MD_Q15   = 3'd0,
        MD_RND   = 3'd1,
        MD_TRUNC = 3'd2,
        MD_Q31   = 3'd3,
        MD_INT   = 3'd4,
        MD_UBH   = 3'd5
    } fmul_mode_e;
endpackage

// File: rtl/fmul_lane.sv
// One 16-bit lane: fractional doubled product, rounded/truncated Q15,
// signed integer low half, and saturating unsigned byte x halfword.
// Assumes: W is even; outputs are purely combinational.
module fmul_lane
    import fmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  fmul_mode_e     mode_i,
    output logic [2*W-1:0] wide_o,
    output logic [W-1:0]   narrow_o,
    output logic           ovf_o
);
    localparam int PW = 2 * W;
    localparam int BW = W / 2;
    localparam int UW = W + BW;
    localparam logic [W-1:0]  MIN_H   = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]  MAX_H   = {1'b0, {(W-1){1'b1}}};
    localparam logic [PW-1:0] MAX_P   = {1'b0, {(PW-1){1'b1}}};
    localparam logic [PW-1:0] RND_INC = PW'(1) << (W - 1);

    logic signed [PW-1:0] a_x, b_x, prod;
    logic [PW-1:0] dbl, rnd;
    logic [UW-1:0] uprod;
    logic both_min, int_ovf, u_ovf;

    // Arithmetic shared by all lane modes.
    always_comb begin
        a_x      = {{W{a_i[W-1]}}, a_i};
        b_x      = {{W{b_i[W-1]}}, b_i};
        prod     = a_x * b_x;
        dbl      = {prod[PW-2:0], 1'b0};
        rnd      = dbl + RND_INC;
        both_min = (a_i == MIN_H) && (b_i == MIN_H);
        int_ovf  = !(&prod[PW-1:W-1]) && (|prod[PW-1:W-1]);
        uprod    = {{W{1'b0}}, a_i[BW-1:0]} * {{BW{1'b0}}, b_i};
        u_ovf    = |uprod[UW-1:W];
    end

    // Per-mode result and overflow selection.
    always_comb begin
        wide_o   = '0;
        narrow_o = '0;
        ovf_o    = 1'b0;
        case (mode_i)
            MD_Q15: begin
                wide_o = both_min ? MAX_P : dbl;
                ovf_o  = both_min;
            end
            MD_RND: begin
                narrow_o = both_min ? MAX_H : rnd[PW-1:W];
                ovf_o    = both_min;
            end
            MD_TRUNC: begin
                narrow_o = both_min ? MAX_H : dbl[PW-1:W];
                ovf_o    = both_min;
            end
            MD_INT: begin
                narrow_o = prod[W-1:0];
                ovf_o    = int_ovf;
            end
            MD_UBH: begin
                narrow_o = u_ovf ? '1 : uprod[W-1:0];
                ovf_o    = u_ovf;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fmul_word.sv
// Full-word fractional multiply: signed DW x DW product doubled, with the
// minimum-times-minimum case saturated.
// Assumes: en_i gates the overflow so other modes never raise it.
module fmul_word #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            en_i,
    output logic [2*DW-1:0] prod_o,
    output logic            ovf_o
);
    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] MIN_W = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] MAX_P = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] a_x, b_x, prod;
    logic both_min;

    // Sign-extended multiply, doubling and saturation of the single corner.
    always_comb begin
        a_x      = {{DW{a_i[DW-1]}}, a_i};
        b_x      = {{DW{b_i[DW-1]}}, b_i};
        prod     = a_x * b_x;
        both_min = (a_i == MIN_W) && (b_i == MIN_W);
        prod_o   = both_min ? MAX_P : {prod[PW-2:0], 1'b0};
        ovf_o    = en_i && both_min;
    end
endmodule

// File: rtl/fixq_mul.sv
// Fractional Q15/Q31 multiplier top: lane array plus word multiplier,
// result mux, one output register stage and a sticky overflow status word.
// Assumes: synchronous active-low reset; overflow routes to the general
// flag or to an accumulator-indexed flag.
module fixq_mul
    import fmul_pkg::*;
#(
    parameter int LANE_W       = 16,
    parameter int LANES        = 2,
    parameter int ACC_W        = 2,
    parameter int STAT_W       = 32,
    parameter int ACC_FLAG_LSB = 16,
    parameter int GEN_FLAG_BIT = 21
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [2:0]                mode,
    input  logic                      acc_tgt,
    input  logic [ACC_W-1:0]          acc_idx,
    input  logic [LANES*LANE_W-1:0]   op_a,
    input  logic [LANES*LANE_W-1:0]   op_b,
    output logic                      out_valid,
    output logic [2*LANES*LANE_W-1:0] result,
    output logic [STAT_W-1:0]         status
);
    localparam int DW = LANES * LANE_W;
    localparam int RW = 2 * DW;
    localparam int PW = 2 * LANE_W;

    fmul_mode_e md;
    logic [PW-1:0]     lane_wide   [LANES];
    logic [LANE_W-1:0] lane_narrow [LANES];
    logic [LANES-1:0]  lane_ovf;
    logic [RW-1:0]     word_prod;
    logic              word_ovf;
    logic [RW-1:0]     next_res;
    logic              any_ovf;
    logic [STAT_W-1:0] flag_vec;
    logic              past_ok;

    assign md = fmul_mode_e'(mode);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fmul_lane #(.W(LANE_W)) u_lane (
            .a_i      (op_a[l*LANE_W +: LANE_W]),
            .b_i      (op_b[l*LANE_W +: LANE_W]),
            .mode_i   (md),
            .wide_o   (lane_wide[l]),
            .narrow_o (lane_narrow[l]),
            .ovf_o    (lane_ovf[l])
        );
    end

    fmul_word #(.DW(DW)) u_word (
        .a_i    (op_a),
        .b_i    (op_b),
        .en_i   (md == MD_Q31),
        .prod_o (word_prod),
        .ovf_o  (word_ovf)
    );

    // Assemble the full result from lane or word outputs by mode.
    always_comb begin
        next_res = '0;
        case (md)
            MD_Q15:
                for (int l = 0; l < LANES; l++) next_res[l*PW +: PW] = lane_wide[l];
            MD_Q31:
                next_res = word_prod;
            MD_RND, MD_TRUNC, MD_INT, MD_UBH:
                for (int l = 0; l < LANES; l++) next_res[l*LANE_W +: LANE_W] = lane_narrow[l];
            default: ;
        endcase
    end

    // Choose the single status bit an overflow of this operation sets.
    always_comb begin
        any_ovf  = word_ovf || (|lane_ovf);
        flag_vec = '0;
        if (acc_tgt) flag_vec[ACC_FLAG_LSB + int'(acc_idx)] = 1'b1;
        else         flag_vec[GEN_FLAG_BIT] = 1'b1;
    end

    // Output register stage and sticky status accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            status    <= '0;
            past_ok   <= 1'b0;
        end else begin
            past_ok   <= 1'b1;
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
            if (in_valid && any_ovf) status <= status | flag_vec;
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((status & $past(status)) == $past(status)));

    // R3
    q15_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd0 && op_a[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}}
         && op_b[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}})
        |=> result[PW-1:0] == {1'b0, {(PW-1){1'b1}}});

    // R4
    q31_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd3 && op_a == {1'b1, {(DW-1){1'b0}}}
         && op_b == {1'b1, {(DW-1){1'b0}}})
        |=> result == {1'b0, {(RW-1){1'b1}}});

    // R9
    gen_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_tgt && mode == 3'd3 && op_a == {1'b1, {(DW-1){1'b0}}}
         && op_b == {1'b1, {(DW-1){1'b0}}})
        |=> status[GEN_FLAG_BIT]);
endmodule

// File: tb/sim_fixq_mul.sv
`timescale 1ns/1ps
module sim_fixq_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        acc_tgt = 1'b0;
    logic [1:0]  acc_idx = 2'd0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_status = '0;
    logic [63:0] last_res = '0;

    always #2.5 clk = ~clk;

    fixq_mul u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .acc_tgt(acc_tgt), .acc_idx(acc_idx), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .status(status)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void model(input int md, input logic [31:0] a, input logic [31:0] b,
                                  output logic [63:0] r, output bit ov);
        r = '0;
        ov = 1'b0;
        if (md == 3) begin
            longint sa = longint'($signed(a));
            longint sb = longint'($signed(b));
            if (a == 32'h8000_0000 && b == 32'h8000_0000) begin
                r = 64'h7FFF_FFFF_FFFF_FFFF;
                ov = 1'b1;
            end else begin
                r = sa * sb * 2;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic [15:0] ah = a[16*i +: 16];
                logic [15:0] bh = b[16*i +: 16];
                longint p = longint'($signed(ah)) * longint'($signed(bh));
                longint d = p * 2;
                longint t = 0;
                longint u = longint'(ah[7:0]) * longint'(bh);
                bit sp = (ah == 16'h8000) && (bh == 16'h8000);
                case (md)
                    0: begin
                        if (sp) begin r[32*i +: 32] = 32'h7FFF_FFFF; ov = 1'b1; end
                        else r[32*i +: 32] = d[31:0];
                    end
                    1: begin
                        t = (d + 32768) >>> 16;
                        if (sp) begin r[16*i +: 16] = 16'h7FFF; ov = 1'b1; end
                        else r[16*i +: 16] = t[15:0];
                    end
                    2: begin
                        t = d >>> 16;
                        if (sp) begin r[16*i +: 16] = 16'h7FFF; ov = 1'b1; end
                        else r[16*i +: 16] = t[15:0];
                    end
                    4: begin
                        if (p > 32767 || p < -32768) ov = 1'b1;
                        r[16*i +: 16] = p[15:0];
                    end
                    5: begin
                        if (u > 65535) begin r[16*i +: 16] = 16'hFFFF; ov = 1'b1; end
                        else r[16*i +: 16] = u[15:0];
                    end
                    default: ;
                endcase
            end
        end
    endfunction

    // Issue one operation, then check valid, result and status after it registers.
    task automatic do_op(input string req, input int md, input logic [31:0] a,
                         input logic [31:0] b, input bit tgt, input int acc);
        logic [63:0] er;
        bit ov;
        model(md, a, b, er, ov);
        if (ov) begin
            if (tgt) exp_status[16 + acc] = 1'b1;
            else     exp_status[21] = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b1; mode = 3'(md); op_a = a; op_b = b;
        acc_tgt = tgt; acc_idx = 2'(acc);
        @(negedge clk);
        in_valid = 1'b0;
        check64({req, " out_valid"}, 64'(out_valid), 64'd1);
        check64({req, " result"}, result, er);
        check64({req, " status"}, 64'(status), 64'(exp_status));
        last_res = er;
    endtask

    task automatic t_reset(input string req);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check64({req, " reset out_valid"}, 64'(out_valid), 64'd0);
        check64({req, " reset result"}, result, 64'd0);
        check64({req, " reset status"}, 64'(status), 64'd0);
        rst_n = 1'b1;
        exp_status = '0;
        last_res = '0;
    endtask

    task automatic t_idle();
        // R1 / R10: idle cycle with corner operands must not touch anything.
        @(negedge clk);
        in_valid = 1'b0; mode = 3'd3; op_a = 32'h8000_0000; op_b = 32'h8000_0000;
        acc_tgt = 1'b1; acc_idx = 2'd3;
        @(negedge clk);
        check64("R1 idle out_valid", 64'(out_valid), 64'd0);
        check64("R1 idle result held", result, last_res);
        check64("R10 idle status unchanged", 64'(status), 64'(exp_status));
    endtask

    task automatic t_q15();
        do_op("R2 q15 mix", 0, 32'h4000_C000, 32'h2000_4000, 1'b0, 0);
        do_op("R2 q15 neg", 0, 32'hFFFF_7FFF, 32'h0001_7FFF, 1'b0, 0);
        do_op("R3 q15 corner lane1", 0, 32'h8000_1234, 32'h8000_0002, 1'b0, 0);
        do_op("R3 q15 corner lane0", 0, 32'h0100_8000, 32'h0003_8000, 1'b1, 1);
    endtask

    task automatic t_q31();
        do_op("R4 q31 plain", 3, 32'h4000_0000, 32'hC000_0001, 1'b0, 0);
        do_op("R4 q31 near corner", 3, 32'h8000_0000, 32'h8000_0001, 1'b0, 0);
        do_op("R4 q31 corner", 3, 32'h8000_0000, 32'h8000_0000, 1'b1, 2);
    endtask

    task automatic t_narrow();
        do_op("R5 rnd", 1, 32'h7FFF_1234, 32'h7FFF_F00F, 1'b0, 0);
        do_op("R5 rnd dual corner", 1, 32'h8000_8000, 32'h8000_8000, 1'b0, 0);
        do_op("R6 trunc", 2, 32'h8000_FFFF, 32'h7FFF_FFFF, 1'b0, 0);
        do_op("R6 trunc corner", 2, 32'h0005_8000, 32'h0007_8000, 1'b1, 3);
    endtask

    task automatic t_int();
        do_op("R7 int in range", 4, 32'h8000_00B5, 32'h0001_00B5, 1'b0, 0);
        do_op("R7 int dual ovf", 4, 32'h0100_FF00, 32'h0100_0100, 1'b0, 0);
    endtask

    task automatic t_ubh();
        do_op("R8 ubh boundary", 5, 32'h00FF_0010, 32'h0101_0FFF, 1'b0, 0);
        do_op("R8 ubh sat", 5, 32'h1202_0001, 32'h8000_FFFF, 1'b1, 0);
    endtask

    task automatic t_route();
        for (int k = 0; k < 4; k++)
            do_op("R9 acc route", 0, 32'h0000_8000, 32'h0000_8000, 1'b1, k);
        do_op("R9 general route", 4, 32'h0000_4000, 32'h0000_0004, 1'b0, 0);
    endtask

    initial begin
        t_reset("R10");
        t_q15();
        t_idle();
        t_q31();
        t_narrow();
        t_int();
        t_ubh();
        t_reset("R10 mid-run");
        t_route();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule